// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side control logic of an ISA-style plug-and-play adapter. The host talks to every card through two fixed write ports and one read port that it can move. A write to the index port (I/O 0x279) selects a card-level register. A write to the data port (I/O 0xA79) writes that register. Reads are taken at the relocatable read-data port. The controller moves the card through four states: waiting for the initiation key, sleeping, isolating and being configured.

The block holds the card select number (CSN), the selected logical device and the read-port address. It decodes the wake and configuration-control commands. It serves a byte-serial stream of resource data from a small internal table, together with a ready flag. The key generator and the bit-serial isolation compare are not part of this block. The key arrives as a one-cycle strobe, and isolation reads return a stub value.

Top module: `pnp_card_cfg`

## Requirements
- R1: After reset: cardState is 0 (wait-for-key), csn is 0, ldn is 0, rdPortAddr is 0x203, resourceReady is 1, ldevReset is 0 and ioRdData is 0x00.
- R2: In wait-for-key (state 0), a keyDetect pulse moves the card to sleep (state 1) at the next edge. Every data-port write other than to index 0x02 is ignored in this state, and reads return 0x00.
- R3: A write at I/O 0x279 latches a register index. A write at I/O 0xA79 writes the register at that index, and its effect is visible after the next clock edge.
- R4: A write to index 0x03 (wake) moves the card from sleep only when the byte equals csn: to isolation (state 2) if the byte is zero, to config (state 3) otherwise. A byte that does not match, or a wake written in any other state, leaves the state unchanged.
- R5: An accepted wake resets the resource pointer to entry 0 and sets the ready flag.
- R6: Writing index 0x02 with bit 0 set gives a single-cycle pulse on ldevReset and leaves csn and the state unchanged.
- R7: Writing index 0x02 with bit 1 set returns the card to wait-for-key and keeps csn. The bits of this register hold no state.
- R8: Writing index 0x02 with bit 2 set clears csn to 0 and leaves the state unchanged.
- R9: Writing byte d to index 0x00 sets rdPortAddr to {d, 2'b11}, so d becomes address bits 9:2. A read of index 0x00 returns 0x00.
- R10: A read is any ioRd at I/O address {2'b00, rdPortAddr} outside wait-for-key. ioRdData carries the result in the following cycle and is 0x00 otherwise. Index 0x04 returns table entry p, which is (p*37+90) mod 256, and then advances p modulo 16.
- R11: Index 0x05 returns the ready flag in bit 0. After each resource read, resourceReady is 0 for exactly one cycle and then 1 again.
- R12: Index 0x06 (csn) reads back the value written. Index 0x07 accepts a write only when the byte is below NUM_LDEV (4) and reads back the stored ldn. Indexes 0x01 and 0x08 to 0x1F read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyDetect | input | 1 | Initiation key recognised (one-cycle strobe) |
| ioAddr | input | 12 | I/O address of the current access |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWrData | input | 8 | Write data byte |
| ioRdData | output | 8 | Read data, valid the cycle after ioRd |
| cardState | output | 2 | 0 wait-for-key, 1 sleep, 2 isolation, 3 config |
| csn | output | 8 | Card select number |
| ldn | output | 2 | Selected logical device |
| rdPortAddr | output | 10 | Current read-port I/O address |
| resourceReady | output | 1 | Next resource byte may be read |
| ldevReset | output | 1 | One-cycle reset pulse for the logical devices |

## Verification
The assertions assume that a single cycle never carries both a write and a read. Under that assumption, an accepted wake and a resource advance cannot coincide, and each strobe in the control struct stands for exactly one access. The bench respects this: it drives one access per task, changes inputs on the falling edge and drops every strobe after one cycle. The bench sweeps all 256 wake bytes and all 256 read-port positions, and it runs the resource stream past its wrap point.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

  typedef enum logic [1:0] {
    ST_WAITKEY = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_ISOLATE = 2'd2,
    ST_CONFIG  = 2'd3
  } cardState_e;

  localparam logic [7:0] IDX_RDPORT  = 8'h00;
  localparam logic [7:0] IDX_ISOL    = 8'h01;
  localparam logic [7:0] IDX_CFGCTL  = 8'h02;
  localparam logic [7:0] IDX_WAKE    = 8'h03;
  localparam logic [7:0] IDX_RESDATA = 8'h04;
  localparam logic [7:0] IDX_STATUS  = 8'h05;
  localparam logic [7:0] IDX_CSN     = 8'h06;
  localparam logic [7:0] IDX_LDN     = 8'h07;

  typedef struct packed {
    logic       loadRdPort;
    logic       loadCsn;
    logic       clearCsn;
    logic       loadLdn;
    logic       ldevRst;
    logic       ptrRst;
    logic       resAdvance;
    logic       rdEn;
    logic [7:0] rdIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/pnp_cfg_ctrl.sv
module pnp_cfg_ctrl
  import pnp_cfg_pkg::*;
#(
  parameter logic [11:0] ADDR_PORT  = 12'h279,
  parameter logic [11:0] WDATA_PORT = 12'hA79
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyDetect,
  input  logic [11:0] ioAddr,
  input  logic        ioWr,
  input  logic        ioRd,
  input  logic [7:0]  ioWrData,
  input  logic [7:0]  csn,
  input  logic [9:0]  rdPortAddr,
  output cardState_e  state,
  output ctrlStrobe_t strb
);

  logic [7:0] regIdx;
  logic       wrAddrPort;
  logic       wrDataPort;
  logic       rdDataPort;
  logic       awake;
  logic       wakeHit;
  logic       cfgReturn;
  cardState_e nextState;

  assign wrAddrPort = ioWr && (ioAddr == ADDR_PORT);
  assign wrDataPort = ioWr && (ioAddr == WDATA_PORT);
  assign rdDataPort = ioRd && (ioAddr == {2'b00, rdPortAddr});
  assign awake      = (state != ST_WAITKEY);
  assign wakeHit    = wrDataPort && (regIdx == IDX_WAKE) &&
                      (state == ST_SLEEP) && (ioWrData == csn);
  assign cfgReturn  = wrDataPort && (regIdx == IDX_CFGCTL) && ioWrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regIdx <= 8'h00;
    end else if (wrAddrPort) begin
      regIdx <= ioWrData;
    end
  end

  always_comb begin
    strb       = '0;
    strb.rdIdx = regIdx;
    if (wrDataPort) begin
      if (regIdx == IDX_CFGCTL) begin
        strb.ldevRst  = ioWrData[0];
        strb.clearCsn = ioWrData[2];
      end else if (awake) begin
        case (regIdx)
          IDX_RDPORT: strb.loadRdPort = 1'b1;
          IDX_CSN:    strb.loadCsn    = 1'b1;
          IDX_LDN:    strb.loadLdn    = 1'b1;
          IDX_WAKE:   strb.ptrRst     = wakeHit;
          default:    ;
        endcase
      end
    end
    strb.rdEn       = rdDataPort && awake;
    strb.resAdvance = rdDataPort && awake && (regIdx == IDX_RESDATA);
  end

  always_comb begin
    nextState = state;
    if (cfgReturn) begin
      nextState = ST_WAITKEY;
    end else if ((state == ST_WAITKEY) && keyDetect) begin
      nextState = ST_SLEEP;
    end else if (wakeHit) begin
      if (ioWrData == 8'h00) nextState = ST_ISOLATE;
      else                   nextState = ST_CONFIG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAITKEY;
    else       state <= nextState;
  end

  // R4: a matching zero byte sends the card to isolation
  assert_wake_iso_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wakeHit && !cfgReturn && ioWrData == 8'h00) |=> state == ST_ISOLATE);

  // R4: a matching nonzero byte sends the card to config
  assert_wake_cfg_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wakeHit && ioWrData != 8'h00) |=> state == ST_CONFIG);

  // R2: without a key the card stays in wait-for-key
  assert_waitkey_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITKEY && !keyDetect) |=> state == ST_WAITKEY);

  // R7: the return bit always lands in wait-for-key
  assert_cfg_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgReturn |=> state == ST_WAITKEY);

endmodule

// File: rtl/pnp_cfg_datapath.sv
module pnp_cfg_datapath
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_LDEV  = 4,
  parameter int ROM_DEPTH = 16,
  parameter int ROM_STEP  = 37,
  parameter int ROM_SEED  = 90,
  localparam int LDN_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1,
  localparam int PTR_W    = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [7:0]       ioWrData,
  output logic [7:0]       csn,
  output logic [LDN_W-1:0] ldn,
  output logic [9:0]       rdPortAddr,
  output logic             ready,
  output logic             ldevReset,
  output logic [7:0]       ioRdData
);

  logic [7:0]       romTab [ROM_DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rdMux;

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign romTab[g] = 8'((g * ROM_STEP + ROM_SEED) % 256);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csn <= 8'h00;
    end else if (strb.clearCsn) begin
      csn <= 8'h00;
    end else if (strb.loadCsn) begin
      csn <= ioWrData;
    end
  end

  if (NUM_LDEV > 1) begin : g_ldn_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ldn <= '0;
      end else if (strb.loadLdn && (int'(ioWrData) < NUM_LDEV)) begin
        ldn <= ioWrData[LDN_W-1:0];
      end
    end
  end else begin : g_ldn_fixed
    assign ldn = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPortAddr <= 10'h203;
    end else if (strb.loadRdPort) begin
      rdPortAddr <= {ioWrData, 2'b11};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr   <= '0;
      ready <= 1'b1;
    end else if (strb.ptrRst) begin
      ptr   <= '0;
      ready <= 1'b1;
    end else begin
      ready <= !strb.resAdvance;
      if (strb.resAdvance) begin
        if (ptr == PTR_W'(ROM_DEPTH - 1)) ptr <= '0;
        else                              ptr <= ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ldevReset <= 1'b0;
    else       ldevReset <= strb.ldevRst;
  end

  always_comb begin
    case (strb.rdIdx)
      IDX_RESDATA: rdMux = romTab[ptr];
      IDX_STATUS:  rdMux = {7'b0, ready};
      IDX_CSN:     rdMux = csn;
      IDX_LDN:     rdMux = {{(8 - LDN_W){1'b0}}, ldn};
      default:     rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          ioRdData <= 8'h00;
    else if (strb.rdEn) ioRdData <= rdMux;
    else                ioRdData <= 8'h00;
  end

  // R11: ready drops right after a resource read
  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resAdvance && !strb.ptrRst) |=> !ready);

  // R11: ready recovers after one idle cycle
  assert_ready_recover_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !strb.resAdvance) |=> ready);

  // R12: stored device number stays within range
  assert_ldn_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    int'(ldn) < ((NUM_LDEV > 1) ? NUM_LDEV : 1));

  // R6: a reset pulse only follows a command that requested it
  assert_ldev_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    ldevReset |-> $past(strb.ldevRst));

  // R8: a clear request empties the card select number
  assert_csn_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCsn |=> csn == 8'h00);

endmodule

// File: rtl/pnp_card_cfg.sv
module pnp_card_cfg
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_LDEV  = 4,
  parameter int ROM_DEPTH = 16,
  localparam int LDN_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyDetect,
  input  logic [11:0]      ioAddr,
  input  logic             ioWr,
  input  logic             ioRd,
  input  logic [7:0]       ioWrData,
  output logic [7:0]       ioRdData,
  output logic [1:0]       cardState,
  output logic [7:0]       csn,
  output logic [LDN_W-1:0] ldn,
  output logic [9:0]       rdPortAddr,
  output logic             resourceReady,
  output logic             ldevReset
);

  cardState_e  state;
  ctrlStrobe_t strb;

  pnp_cfg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .keyDetect  (keyDetect),
    .ioAddr     (ioAddr),
    .ioWr       (ioWr),
    .ioRd       (ioRd),
    .ioWrData   (ioWrData),
    .csn        (csn),
    .rdPortAddr (rdPortAddr),
    .state      (state),
    .strb       (strb)
  );

  pnp_cfg_datapath #(
    .NUM_LDEV  (NUM_LDEV),
    .ROM_DEPTH (ROM_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ioWrData   (ioWrData),
    .csn        (csn),
    .ldn        (ldn),
    .rdPortAddr (rdPortAddr),
    .ready      (resourceReady),
    .ldevReset  (ldevReset),
    .ioRdData   (ioRdData)
  );

  assign cardState = state;

  // R2: card select number cannot change in wait-for-key except by clear
  assert_csn_waitkey_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cardState == 2'd0 && csn != 8'h00) |=> $stable(csn) || csn == 8'h00);

endmodule

// File: tb/pnp_card_cfg_test.sv
`timescale 1ns/1ps
module pnp_card_cfg_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyDetect = 1'b0;
  logic [11:0] ioAddr = 12'h000;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWrData = 8'h00;
  logic [7:0]  ioRdData;
  logic [1:0]  cardState;
  logic [7:0]  csn;
  logic [1:0]  ldn;
  logic [9:0]  rdPortAddr;
  logic        resourceReady;
  logic        ldevReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [9:0] rdPortExp = 10'h203;

  always #2 clk = ~clk;

  pnp_card_cfg uut (
    .clk(clk), .rstN(rstN), .keyDetect(keyDetect), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .cardState(cardState), .csn(csn), .ldn(ldn), .rdPortAddr(rdPortAddr),
    .resourceReady(resourceReady), .ldevReset(ldevReset)
  );

  function automatic logic [7:0] romVal(input int i);
    return 8'(((i % 16) * 37 + 90) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrAddr(input logic [7:0] idx);
    @(negedge clk); ioAddr = 12'h279; ioWrData = idx; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] d);
    @(negedge clk); ioAddr = 12'hA79; ioWrData = d; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] d);
    wrAddr(idx);
    wrData(d);
  endtask

  task automatic rdCycle(output logic [7:0] v);
    @(negedge clk); ioAddr = {2'b00, rdPortExp}; ioRd = 1'b1;
    @(negedge clk); v = ioRdData; ioRd = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] v);
    wrAddr(idx);
    rdCycle(v);
  endtask

  task automatic keyPulse();
    @(negedge clk); keyDetect = 1'b1;
    @(negedge clk); keyDetect = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    logic [7:0] v;
    logic [1:0] ldnExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 state", cardState, 0);
    chk("R1 csn", csn, 0);
    chk("R1 ldn", ldn, 0);
    chk("R1 rdPortAddr", rdPortAddr, 10'h203);
    chk("R1 ready", resourceReady, 1);
    chk("R1 ldevReset", ldevReset, 0);
    chk("R1 ioRdData", ioRdData, 0);

    // R2: writes other than config-control ignored while waiting for key
    wrReg(8'h06, 8'h05);
    chk("R2 csn ignored", csn, 0);
    wrReg(8'h00, 8'h10);
    chk("R2 rdport ignored", rdPortAddr, 10'h203);
    rdReg(8'h05, v);
    chk("R2 read blocked", v, 0);
    keyPulse();
    chk("R2 key to sleep", cardState, 1);

    // R3 and R12: csn write and readback in sleep
    wrReg(8'h06, 8'h03);
    chk("R3 csn write", csn, 3);
    rdReg(8'h06, v);
    chk("R12 csn read", v, 3);

    // R4: sweep all wake bytes against csn 3
    wrAddr(8'h03);
    for (int d = 0; d < 256; d++) begin
      wrData(8'(d));
      chk("R4 wake sweep", cardState, (d == 3) ? 3 : 1);
      if (d == 3) begin
        wrData(8'h00);
        chk("R4 wake outside sleep", cardState, 3);
        wrReg(8'h02, 8'h02);
        chk("R7 return to waitkey", cardState, 0);
        chk("R7 csn kept", csn, 3);
        keyPulse();
        wrAddr(8'h03);
      end
    end

    // R4: zero csn wakes into isolation
    wrReg(8'h06, 8'h00);
    wrReg(8'h03, 8'h00);
    chk("R4 wake isolation", cardState, 2);
    rdReg(8'h01, v);
    chk("R12 isolation stub", v, 0);
    wrReg(8'h02, 8'h02);
    chk("R7 iso to waitkey", cardState, 0);
    keyPulse();
    wrReg(8'h06, 8'h21);
    wrReg(8'h03, 8'h21);
    chk("R4 wake config", cardState, 3);

    // R9: sweep every read-port position
    for (int d = 0; d < 256; d++) begin
      wrReg(8'h00, 8'(d));
      rdPortExp = {8'(d), 2'b11};
      chk("R9 rdPortAddr", rdPortAddr, rdPortExp);
      rdCycle(v);
      chk("R9 index0 read", v, 0);
      rdReg(8'h06, v);
      chk("R10 read via moved port", v, 8'h21);
    end
    wrReg(8'h00, 8'h80);
    rdPortExp = 10'h203;

    // R10 and R11: resource stream past wrap
    wrAddr(8'h04);
    for (int i = 0; i < 20; i++) begin
      rdCycle(v);
      chk("R10 resource byte", v, romVal(i));
      chk("R11 ready low", resourceReady, 0);
      @(negedge clk);
      chk("R11 ready back", resourceReady, 1);
    end
    rdReg(8'h05, v);
    chk("R11 status bit", v, 1);

    // R5: accepted wake resets the pointer
    wrAddr(8'h04);
    for (int i = 0; i < 3; i++) rdCycle(v);
    chk("R10 resource byte 23", v, romVal(22));
    wrReg(8'h02, 8'h02);
    keyPulse();
    wrReg(8'h03, 8'h21);
    chk("R5 config again", cardState, 3);
    chk("R5 ready set", resourceReady, 1);
    rdReg(8'h04, v);
    chk("R5 pointer reset", v, romVal(0));

    // R6: logical device reset pulse
    wrReg(8'h02, 8'h01);
    chk("R6 pulse high", ldevReset, 1);
    chk("R6 csn kept", csn, 8'h21);
    chk("R6 state kept", cardState, 3);
    @(negedge clk);
    chk("R6 pulse low", ldevReset, 0);

    // R12: logical device select sweep
    ldnExp = 2'd0;
    for (int d = 0; d < 8; d++) begin
      wrReg(8'h07, 8'(d));
      if (d < 4) ldnExp = 2'(d);
      chk("R12 ldn", ldn, ldnExp);
      rdReg(8'h07, v);
      chk("R12 ldn read", v, ldnExp);
    end

    // R12: reserved indexes read zero
    for (int idx = 8; idx < 32; idx++) begin
      rdReg(8'(idx), v);
      chk("R12 reserved", v, 0);
    end

    // R8: csn clear
    wrReg(8'h02, 8'h04);
    chk("R8 csn cleared", csn, 0);
    chk("R8 state kept", cardState, 3);
    chk("R7 no pulse left", ldevReset, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule